// File: doc/BRIEF.md
# Programmable Counter/Timer Baud Generator

This block derives 16x oversampling strobes for the receivers and transmitters of several serial channels from the device clock. Software loads a 16-bit preset through two byte-wide registers and picks timer mode in an auxiliary control register. A bus read of the start address then launches the counter. The counter counts the preset down, reloads it and toggles an internal square wave. Every rising edge of that square wave is one 16x strobe, so the bit rate is the input clock divided by 32 times the preset.

Each channel has a byte-wide clock select register. The receiver takes its source code from the low nibble and the transmitter from the high nibble. Code 0xD routes the timer strobe to that direction. Any other code passes through a strobe supplied from outside by a fixed-rate generator, which is not part of this block. One bit of the auxiliary register picks between two fixed-rate sets and is driven out to that generator.

Top module: `ctb_baudgen`

## Requirements
- R1: After reset all receive and transmit strobes and `rate_set` are 0, and the counter stays idle until a start command, whatever the mode and select codes are.
- R2: A bus read at offset 0xE starts or restarts the counter. A bus write to offset 0xE does not start it.
- R3: While running in timer mode, a direction selecting code 0xD strobes for the first time on the P-th clock edge after the edge that samples the start read. After that it strobes once every 2·P cycles, where P is the effective preset.
- R4: The preset is formed from two bytes: the upper byte is written at offset 6 and the lower byte at offset 7. A preset of 0 or 1 behaves as 2.
- R5: A preset written while the counter runs takes effect at the next reload or at the next start, whichever comes first. The half period already in progress keeps its old length.
- R6: The counter advances only while bits [6:4] of the auxiliary register at offset 4 hold 6. With any other value it holds its position and gives no strobes, and it resumes from that position when timer mode returns.
- R7: The clock select register of channel c is at offset 8·c+1. Its low nibble picks the receive source and its high nibble the transmit source. Code 0xD selects the timer strobe; any other code selects `table_tick[c]`. Each output is registered one cycle after its source.
- R8: `rate_set` equals bit 7 of the last value written at offset 4, from the cycle after the write.
- R9: A start read while the counter runs discards the current phase and restarts timing as in R3.
- R10: Timer strobes last one cycle and are never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (only decoded for the start command) |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| table_tick | input | NCH | Fixed-rate 16x strobe per channel from an external generator |
| rx_tick | output | NCH | 16x receive strobe per channel |
| tx_tick | output | NCH | 16x transmit strobe per channel |
| rate_set | output | 1 | Fixed-rate set selection for the external generator |

## Verification
The properties assume that `bus_wr` and `bus_rd` are never asserted in the same cycle. They also assume that every channel's select offset fits within the address width. The stimulus makes at most one bus access per cycle and uses only the two channels of the default configuration. Table strobes are driven as arbitrary bit patterns, since the assertions put no timing constraint on them. Preset changes, mode changes and restarts are issued at arbitrary counter phases, including during a half period, so the reload boundary of R5 is exercised.

// File: rtl/ctb_pkg.sv
package ctb_pkg;
    localparam int BYTE_W     = 8;
    localparam int CH_STRIDE  = 8;
    localparam int OFS_CLKSEL = 1;
    localparam int OFS_AUX    = 4;
    localparam int OFS_PRE_HI = 6;
    localparam int OFS_PRE_LO = 7;
    localparam int OFS_START  = 14;

    localparam logic [3:0] SEL_TIMER  = 4'hD;
    localparam logic [2:0] MODE_TIMER = 3'd6;
endpackage

// File: rtl/ctb_regs.sv
module ctb_regs
    import ctb_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [BYTE_W-1:0]          bus_wdata,
    output logic [CNT_W-1:0]           preset,
    output logic [2:0]                 mode,
    output logic                       set_sel,
    output logic [NCH-1:0][3:0]        rx_code,
    output logic [NCH-1:0][3:0]        tx_code,
    output logic                       start_pulse
);
    localparam int HI_W = CNT_W - BYTE_W;
    localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(OFS_AUX);
    localparam logic [ADDR_W-1:0] A_HI    = ADDR_W'(OFS_PRE_HI);
    localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(OFS_PRE_LO);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);

    typedef struct packed {
        logic [CNT_W-1:0]             preset;
        logic [BYTE_W-1:0]            aux;
        logic [NCH-1:0][BYTE_W-1:0]   sel;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (bus_wr) begin
            if (bus_addr == A_AUX) r_d.aux = bus_wdata;
            if (bus_addr == A_HI)  r_d.preset[CNT_W-1:BYTE_W] = HI_W'(bus_wdata);
            if (bus_addr == A_LO)  r_d.preset[BYTE_W-1:0] = bus_wdata;
            for (int c = 0; c < NCH; c++) begin
                if (bus_addr == ADDR_W'(c * CH_STRIDE + OFS_CLKSEL)) r_d.sel[c] = bus_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign start_pulse = bus_rd && (bus_addr == A_START);
    assign preset      = r_q.preset;
    assign mode        = r_q.aux[6:4];
    assign set_sel     = r_q.aux[7];

    for (genvar c = 0; c < NCH; c++) begin : g_code
        assign rx_code[c] = r_q.sel[c][3:0];
        assign tx_code[c] = r_q.sel[c][7:4];
    end
endmodule

// File: rtl/ctb_counter.sv
module ctb_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             enable,
    input  logic [CNT_W-1:0] preset,
    output logic             rise,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    localparam logic [CNT_W-1:0] MIN_PRESET = CNT_W'(2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sq;
        logic             run;
    } tmr_t;

    tmr_t s_d, s_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = ((preset < MIN_PRESET) ? MIN_PRESET : preset) - CNT_W'(1);
        s_d    = s_q;
        rise   = s_q.run && enable && (s_q.cnt == '0) && !s_q.sq && !start;
        if (start) begin
            s_d.cnt = reload;
            s_d.sq  = 1'b0;
            s_d.run = 1'b1;
        end else if (s_q.run && enable) begin
            if (s_q.cnt == '0) begin
                s_d.cnt = reload;
                s_d.sq  = ~s_q.sq;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count   = s_q.cnt;
    assign running = s_q.run;
endmodule

// File: rtl/ctb_route.sv
module ctb_route
    import ctb_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                timer_rise,
    input  logic [NCH-1:0]      table_tick,
    input  logic [NCH-1:0][3:0] rx_code,
    input  logic [NCH-1:0][3:0] tx_code,
    output logic [NCH-1:0]      rx_tick,
    output logic [NCH-1:0]      tx_tick
);
    typedef struct packed {
        logic [NCH-1:0] rx;
        logic [NCH-1:0] tx;
    } tick_t;

    tick_t o_d, o_q;
    logic [NCH-1:0] rx_src, tx_src;

    for (genvar c = 0; c < NCH; c++) begin : g_sel
        assign rx_src[c] = (rx_code[c] == SEL_TIMER) ? timer_rise : table_tick[c];
        assign tx_src[c] = (tx_code[c] == SEL_TIMER) ? timer_rise : table_tick[c];
    end

    always_comb begin
        o_d    = o_q;
        o_d.rx = rx_src;
        o_d.tx = tx_src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) o_q <= '0;
        else        o_q <= o_d;
    end

    assign rx_tick = o_q.rx;
    assign tx_tick = o_q.tx;
endmodule

// File: rtl/ctb_baudgen.sv
module ctb_baudgen
    import ctb_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic [NCH-1:0]    table_tick,
    output logic [NCH-1:0]    rx_tick,
    output logic [NCH-1:0]    tx_tick,
    output logic              rate_set
);
    logic [CNT_W-1:0]    preset;
    logic [2:0]          mode;
    logic                start_pulse;
    logic                timer_rise;
    logic                tmr_en;
    logic                tmr_run;
    logic [CNT_W-1:0]    tmr_count;
    logic [NCH-1:0][3:0] rx_code;
    logic [NCH-1:0][3:0] tx_code;

    ctb_regs #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .preset(preset),
        .mode(mode), .set_sel(rate_set), .rx_code(rx_code),
        .tx_code(tx_code), .start_pulse(start_pulse)
    );

    assign tmr_en = (mode == MODE_TIMER);

    ctb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .start(start_pulse), .enable(tmr_en),
        .preset(preset), .rise(timer_rise), .count(tmr_count), .running(tmr_run)
    );

    ctb_route #(.NCH(NCH)) u_route (
        .clk(clk), .rst_n(rst_n), .timer_rise(timer_rise),
        .table_tick(table_tick), .rx_code(rx_code), .tx_code(tx_code),
        .rx_tick(rx_tick), .tx_tick(tx_tick)
    );
endmodule

// File: rtl/ctb_baudgen_chk.sv
module ctb_baudgen_chk
    import ctb_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [7:0]          bus_wdata,
    input logic [NCH-1:0]      rx_tick,
    input logic [NCH-1:0]      tx_tick,
    input logic                rate_set,
    input logic                start_pulse,
    input logic                timer_rise,
    input logic                tmr_en,
    input logic                tmr_run,
    input logic [CNT_W-1:0]    tmr_count,
    input logic [NCH-1:0][3:0] rx_code,
    input logic [NCH-1:0][3:0] tx_code
);
    localparam logic [ADDR_W-1:0] A_START = ADDR_W'(OFS_START);
    localparam logic [ADDR_W-1:0] A_AUX   = ADDR_W'(OFS_AUX);

    initial begin
        a_r7_map_fits: assert (NCH * CH_STRIDE <= (1 << ADDR_W));
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_quiet: assert (rx_tick == '0 && tx_tick == '0 && !rate_set && !tmr_run);
        end
    end

    a_r2_read_starts: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> tmr_run);

    a_r2_write_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_rd && bus_addr == A_START && !tmr_run) |=> !tmr_run);

    a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
        timer_rise |=> !timer_rise);

    a_r4_reload_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && tmr_en && tmr_count == '0 && !start_pulse) |=> (tmr_count != '0));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_run && !tmr_en && !start_pulse) |=> $stable(tmr_count));

    a_r8_rate_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_AUX) |=> (rate_set == $past(bus_wdata[7])));

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        a_r7_rx_timer: assert property (@(posedge clk) disable iff (!rst_n)
            (rx_code[c] == SEL_TIMER) |=> (rx_tick[c] == $past(timer_rise)));
        a_r7_tx_timer: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_code[c] == SEL_TIMER) |=> (tx_tick[c] == $past(timer_rise)));
    end
endmodule

bind ctb_baudgen ctb_baudgen_chk #(.NCH(NCH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/ctb_baudgen_bench.sv
module ctb_baudgen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [1:0] table_tick = '0;
    logic [1:0] rx_tick, tx_tick;
    logic       rate_set;

    int checks = 0;
    int fails = 0;
    string cur_req = "R1";

    int m_pre = 0, m_aux = 0, m_run = 0, m_remain = 0, m_level = 0;
    int m_sel[NCH];
    bit exp_rx[NCH], exp_tx[NCH];
    bit exp_set = 0;
    int cnt_rx0 = 0, cnt_tx0 = 0, dbl = 0;
    bit prev_rx0 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctb_baudgen u_ctb_baudgen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .table_tick(table_tick),
        .rx_tick(rx_tick), .tx_tick(tx_tick), .rate_set(rate_set)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step(input bit wr, input bit rd, input int addr, input int wd, input logic [1:0] tt);
        int peff;
        bit fire;
        fire = 0;
        peff = (m_pre < 2) ? 2 : m_pre;
        if (rd && addr == 14) begin
            m_run = 1; m_remain = peff; m_level = 0;
        end else if (m_run != 0 && ((m_aux >> 4) & 7) == 6) begin
            m_remain--;
            if (m_remain == 0) begin
                m_level = 1 - m_level;
                if (m_level == 1) fire = 1;
                m_remain = peff;
            end
        end
        for (int c = 0; c < NCH; c++) begin
            exp_rx[c] = ((m_sel[c] & 15) == 13) ? fire : tt[c];
            exp_tx[c] = (((m_sel[c] >> 4) & 15) == 13) ? fire : tt[c];
        end
        if (wr) begin
            case (addr)
                1:  m_sel[0] = wd;
                9:  m_sel[1] = wd;
                4:  m_aux = wd;
                6:  m_pre = (m_pre & 255) | (wd << 8);
                7:  m_pre = (m_pre & 'hFF00) | wd;
                default: ;
            endcase
        end
        exp_set = ((m_aux >> 7) & 1) != 0;
    endtask

    task automatic cyc(input bit wr, input bit rd, input int addr, input int wd, input logic [1:0] tt);
        bus_wr = wr; bus_rd = rd; bus_addr = 4'(addr); bus_wdata = 8'(wd); table_tick = tt;
        @(posedge clk);
        model_step(wr, rd, addr, wd, tt);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            chk(rx_tick[c] == exp_rx[c], cur_req, $sformatf("rx_tick[%0d]", c), int'(rx_tick[c]), int'(exp_rx[c]));
            chk(tx_tick[c] == exp_tx[c], cur_req, $sformatf("tx_tick[%0d]", c), int'(tx_tick[c]), int'(exp_tx[c]));
        end
        chk(rate_set == exp_set, cur_req, "rate_set", int'(rate_set), int'(exp_set));
        if (rx_tick[0] && prev_rx0 && m_sel[0] == 'hDD) dbl++;
        prev_rx0 = rx_tick[0];
        cnt_rx0 += int'(rx_tick[0]);
        cnt_tx0 += int'(tx_tick[0]);
    endtask

    task automatic wr_reg(input int addr, input int wd);
        cyc(1, 0, addr, wd, 2'b00);
    endtask

    task automatic start_tmr();
        cyc(0, 1, 14, 0, 2'b00);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 2'b00);
    endtask

    task automatic clr();
        cnt_rx0 = 0; cnt_tx0 = 0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) m_sel[c] = 0;
        repeat (3) @(negedge clk);
        chk(rx_tick == 2'b00 && tx_tick == 2'b00, "R1", "ticks in reset", int'({rx_tick, tx_tick}), 0);
        chk(rate_set == 1'b0, "R1", "rate_set in reset", int'(rate_set), 0);
        rst_n = 1'b1;

        cur_req = "R1";
        wr_reg(4, 'h60);
        wr_reg(1, 'hDD);
        clr(); idle(20);
        chk(cnt_rx0 == 0, "R1", "ticks before start", cnt_rx0, 0);

        cur_req = "R2";
        wr_reg(14, 'hFF);
        clr(); idle(20);
        chk(cnt_rx0 == 0, "R2", "ticks after write to start offset", cnt_rx0, 0);

        cur_req = "R3";
        wr_reg(6, 0);
        wr_reg(7, 5);
        start_tmr();
        clr(); idle(100);
        chk(cnt_rx0 == 10, "R3", "rx ticks in 100 cycles with preset 5", cnt_rx0, 10);
        chk(cnt_tx0 == 10, "R3", "tx ticks in 100 cycles with preset 5", cnt_tx0, 10);

        cur_req = "R4";
        wr_reg(7, 1);
        start_tmr();
        clr(); idle(40);
        chk(cnt_rx0 == 10, "R4", "ticks with preset 1 treated as 2", cnt_rx0, 10);
        wr_reg(7, 0);
        start_tmr();
        clr(); idle(40);
        chk(cnt_rx0 == 10, "R4", "ticks with preset 0 treated as 2", cnt_rx0, 10);
        wr_reg(6, 1);
        wr_reg(7, 2);
        start_tmr();
        clr(); idle(1100);
        chk(cnt_rx0 == 2, "R4", "ticks with preset 0x0102", cnt_rx0, 2);

        cur_req = "R5";
        wr_reg(6, 0);
        wr_reg(7, 4);
        start_tmr();
        idle(6);
        wr_reg(7, 7);
        clr(); idle(60);
        wr_reg(7, 3);
        idle(30);

        cur_req = "R6";
        wr_reg(4, 'h00);
        clr(); idle(30);
        chk(cnt_rx0 == 0, "R6", "ticks outside timer mode", cnt_rx0, 0);
        wr_reg(4, 'h50);
        idle(10);
        wr_reg(4, 'h60);
        idle(40);

        cur_req = "R7";
        wr_reg(1, 'h3D);
        wr_reg(9, 'hD2);
        for (int i = 0; i < 48; i++) cyc(0, 0, 0, 0, 2'(i ^ (i >> 2)));
        wr_reg(1, 'hD7);
        wr_reg(9, 'h0D);
        for (int i = 0; i < 48; i++) cyc(0, 0, 0, 0, 2'(3 * i));

        cur_req = "R8";
        wr_reg(4, 'hE0);
        chk(rate_set == 1'b1, "R8", "rate_set after bit7 set", int'(rate_set), 1);
        wr_reg(4, 'h60);
        chk(rate_set == 1'b0, "R8", "rate_set after bit7 clear", int'(rate_set), 0);

        cur_req = "R9";
        wr_reg(1, 'hDD);
        wr_reg(7, 6);
        start_tmr();
        idle(4);
        start_tmr();
        clr(); idle(6);
        chk(cnt_rx0 == 1, "R9", "tick after restart lands at preset", cnt_rx0, 1);
        idle(30);

        cur_req = "R10";
        wr_reg(7, 2);
        start_tmr();
        dbl = 0;
        idle(40);
        chk(dbl == 0, "R10", "back-to-back timer ticks", dbl, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule